// File: doc/BRIEF.md
# Page-Granular Cache Tag and Line-State Directory

This block keeps the tags and coherence state for a cache that claims storage one whole page at a time. It has 2^ENTRY_BITS slots, and every slot can hold any page. Each slot has two tag copies. The processor copy holds a logical or physical page tag together with a process identifier. The bus copy holds the translated physical page tag. The two copies share one slot index. Each slot also carries a valid, exclusive and owned (modified) bit for every line of its page. Both copies keep their own set of these bits, so a bus snoop never has to read the processor side.

Lookups are combinational and return their result in the same cycle. State changes take effect at the next rising clock edge. The surrounding cache controller uses the block as follows:
- It allocates slots at the suggested victim.
- It reports line fills, processor writes and line write-backs.
- It withdraws all pages of a process with one flush command.
- It drains modified lines using the per-slot dirty flags and the next-modified-line search.

Top module: `pac_desc_array`

## Requirements
- R1: After reset every slot is free and holds no valid or owned line. No processor or snoop lookup hits, `ent_dirty` is all zero, and the victim is slot 0 with `victim_valid`=1.
- R2: A processor lookup hits a page only in a live slot whose processor tag equals `cpu_addr[ADDR_W-1:PAGE_BITS]` and whose process identifier equals `cpu_pid`. `cpu_attr` is {valid, exclusive, owned} (bit 2 down to bit 0) of line `cpu_addr[PAGE_BITS-1:LINE_BITS]` from the processor copy. `cpu_hit` is the page hit ANDed with that valid bit, and `cpu_pstat` is the slot's page status bit. All of these outputs are zero on a miss.
- R3: A snoop lookup compares only the bus-side physical tag, in live and draining slots. In the same cycle it returns the slot index and the line's {valid, exclusive, owned} bits from the bus copy.
- R4: An allocation writes both tags, the process identifier and the page status bit of slot `alloc_idx`, and clears all line bits in both copies. An allocation to a slot that still has an owned line is ignored.
- R5: A fill sets the line's valid bit, and sets its exclusive bit to `fill_excl`, in both copies. A fill to a slot that is not live is ignored.
- R6: A processor write sets the owned bit of a valid line in both copies. A write to an invalid line is ignored.
- R7: A write-back clears the owned bit of the named line in both copies.
- R8: `ent_dirty[i]` is the OR of the owned bits of all lines in slot i.
- R9: A flush removes every live slot whose identifier equals `flush_pid` from the processor side within one cycle. Clean slots become free at once. Dirty slots keep answering snoops and stay non-replaceable until their last owned line is written back, and then become free.
- R10: The victim is the lowest-index slot that is not live and not dirty. If there is none, it is the lowest-index live clean slot. If every slot is dirty, `victim_valid` is 0.
- R11: `scan_line` names the lowest-index owned line of slot `scan_idx`. `scan_found` is 0 when that slot has no owned line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | ADDR_W-LINE_BITS | Processor line address (page tag and line index) |
| cpu_pid | input | PID_W | Processor process identifier |
| cpu_page_hit | output | 1 | Processor page matched |
| cpu_hit | output | 1 | Page matched and line valid |
| cpu_idx | output | ENTRY_BITS | Matching slot |
| cpu_attr | output | 3 | {valid, exclusive, owned} of the processor copy |
| cpu_pstat | output | 1 | Page status bit of the matching slot |
| snp_addr | input | ADDR_W-LINE_BITS | Bus physical line address |
| snp_page_hit | output | 1 | Bus page matched |
| snp_idx | output | ENTRY_BITS | Matching slot |
| snp_attr | output | 3 | {valid, exclusive, owned} of the bus copy |
| alloc_en | input | 1 | Allocate strobe |
| alloc_idx | input | ENTRY_BITS | Slot to load |
| alloc_ptag | input | ADDR_W-PAGE_BITS | Processor-side page tag |
| alloc_stag | input | ADDR_W-PAGE_BITS | Bus-side physical page tag |
| alloc_pid | input | PID_W | Process identifier |
| alloc_pstat | input | 1 | Local-memory page status copy |
| fill_en | input | 1 | Line fill strobe |
| fill_idx | input | ENTRY_BITS | Slot of the fill |
| fill_line | input | PAGE_BITS-LINE_BITS | Line of the fill |
| fill_excl | input | 1 | Filled line is exclusive |
| wr_en | input | 1 | Processor write strobe |
| wr_idx | input | ENTRY_BITS | Slot written |
| wr_line | input | PAGE_BITS-LINE_BITS | Line written |
| wb_en | input | 1 | Write-back done strobe |
| wb_idx | input | ENTRY_BITS | Slot written back |
| wb_line | input | PAGE_BITS-LINE_BITS | Line written back |
| flush_en | input | 1 | Flush-by-process strobe |
| flush_pid | input | PID_W | Process to flush |
| ent_dirty | output | 2^ENTRY_BITS | Per-slot owned-line OR |
| victim_valid | output | 1 | A replaceable slot exists |
| victim_idx | output | ENTRY_BITS | Suggested slot to allocate |
| scan_idx | input | ENTRY_BITS | Slot to search for owned lines |
| scan_found | output | 1 | Searched slot has an owned line |
| scan_line | output | PAGE_BITS-LINE_BITS | Lowest owned line in that slot |

## Verification
The bench targets the following corner cases:
- A write to a line that was never filled. A design that set the owned bit regardless would raise `ent_dirty` and block replacement.
- A re-allocation aimed at a dirty slot. A design that accepted it would lose modified data, which shows up as the old tag no longer hitting.
- A flush that leaves dirty slots draining. A faulty design would either keep hitting on the processor side or drop the snoop match before write-back. The test also checks that a fill into a draining slot is ignored.
- A table filled with dirty slots, then a single write-back. A design with the wrong victim ordering would report a replaceable slot too early or pick the wrong one.

// File: rtl/pac_pkg.sv
package pac_pkg;
   typedef enum logic [1:0] {
      ENT_FREE  = 2'd0,
      ENT_LIVE  = 2'd1,
      ENT_DRAIN = 2'd2
   } ent_state_e;

   typedef struct packed {
      logic v;
      logic x;
      logic o;
   } line_attr_t;
endpackage

// File: rtl/pac_prio.sv
module pac_prio #(
   parameter int N = 32,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   generate
      if (N == 1) begin : g_single
         assign found = req[0];
         assign idx   = '0;
      end else begin : g_scan
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) begin
                  found = 1'b1;
                  idx   = IW'(i);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pac_match.sv
module pac_match #(
   parameter int N     = 32,
   parameter int KEY_W = 22
) (
   input  logic [N-1:0]            en,
   input  logic [N-1:0][KEY_W-1:0] keys,
   input  logic [KEY_W-1:0]        key,
   output logic [N-1:0]            hit
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit[i] = en[i] && (keys[i] == key);
   end
endmodule

// File: rtl/pac_line_store.sv
module pac_line_store
   import pac_pkg::*;
#(
   parameter int N     = 32,
   parameter int LINES = 16,
   localparam int IW = $clog2(N),
   localparam int LW = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [IW-1:0]    clr_idx,
   input  logic             fill_en,
   input  logic [IW-1:0]    fill_idx,
   input  logic [LW-1:0]    fill_line,
   input  logic             fill_excl,
   input  logic             own_en,
   input  logic [IW-1:0]    own_idx,
   input  logic [LW-1:0]    own_line,
   input  logic             wb_en,
   input  logic [IW-1:0]    wb_idx,
   input  logic [LW-1:0]    wb_line,
   input  logic [IW-1:0]    rd_idx,
   input  logic [LW-1:0]    rd_line,
   output line_attr_t       rd_attr,
   input  logic [IW-1:0]    sel_idx,
   output logic [LINES-1:0] sel_owned,
   output logic [N-1:0]     dirty
);
   line_attr_t ln_q [N][LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < N; e++)
            for (int l = 0; l < LINES; l++)
               ln_q[e][l] <= '0;
      end else begin
         for (int e = 0; e < N; e++) begin
            for (int l = 0; l < LINES; l++) begin
               if (clr_en && clr_idx == IW'(e)) begin
                  ln_q[e][l] <= '0;
               end else begin
                  if (fill_en && fill_idx == IW'(e) && fill_line == LW'(l)) begin
                     ln_q[e][l].v <= 1'b1;
                     ln_q[e][l].x <= fill_excl;
                  end
                  if (own_en && own_idx == IW'(e) && own_line == LW'(l) && ln_q[e][l].v)
                     ln_q[e][l].o <= 1'b1;
                  if (wb_en && wb_idx == IW'(e) && wb_line == LW'(l))
                     ln_q[e][l].o <= 1'b0;
               end
            end
         end
      end
   end

   assign rd_attr = ln_q[rd_idx][rd_line];

   always_comb begin
      for (int l = 0; l < LINES; l++)
         sel_owned[l] = ln_q[sel_idx][l].o;
   end

   for (genvar e = 0; e < N; e++) begin : g_dirty
      logic any_o;
      always_comb begin
         any_o = 1'b0;
         for (int l = 0; l < LINES; l++)
            any_o = any_o | ln_q[e][l].o;
      end
      assign dirty[e] = any_o;
   end
endmodule

// File: rtl/pac_desc_array.sv
module pac_desc_array
   import pac_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_BITS  = 10,
   parameter int LINE_BITS  = 6,
   parameter int ENTRY_BITS = 5,
   parameter int PID_W      = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:LINE_BITS]       cpu_addr,
   input  logic [PID_W-1:0]                cpu_pid,
   output logic                            cpu_page_hit,
   output logic                            cpu_hit,
   output logic [ENTRY_BITS-1:0]           cpu_idx,
   output logic [2:0]                      cpu_attr,
   output logic                            cpu_pstat,
   input  logic [ADDR_W-1:LINE_BITS]       snp_addr,
   output logic                            snp_page_hit,
   output logic [ENTRY_BITS-1:0]           snp_idx,
   output logic [2:0]                      snp_attr,
   input  logic                            alloc_en,
   input  logic [ENTRY_BITS-1:0]           alloc_idx,
   input  logic [ADDR_W-PAGE_BITS-1:0]     alloc_ptag,
   input  logic [ADDR_W-PAGE_BITS-1:0]     alloc_stag,
   input  logic [PID_W-1:0]                alloc_pid,
   input  logic                            alloc_pstat,
   input  logic                            fill_en,
   input  logic [ENTRY_BITS-1:0]           fill_idx,
   input  logic [PAGE_BITS-LINE_BITS-1:0]  fill_line,
   input  logic                            fill_excl,
   input  logic                            wr_en,
   input  logic [ENTRY_BITS-1:0]           wr_idx,
   input  logic [PAGE_BITS-LINE_BITS-1:0]  wr_line,
   input  logic                            wb_en,
   input  logic [ENTRY_BITS-1:0]           wb_idx,
   input  logic [PAGE_BITS-LINE_BITS-1:0]  wb_line,
   input  logic                            flush_en,
   input  logic [PID_W-1:0]                flush_pid,
   output logic [(1<<ENTRY_BITS)-1:0]      ent_dirty,
   output logic                            victim_valid,
   output logic [ENTRY_BITS-1:0]           victim_idx,
   input  logic [ENTRY_BITS-1:0]           scan_idx,
   output logic                            scan_found,
   output logic [PAGE_BITS-LINE_BITS-1:0]  scan_line
);
   localparam int ENTRIES = 1 << ENTRY_BITS;
   localparam int TAG_W   = ADDR_W - PAGE_BITS;
   localparam int LW      = PAGE_BITS - LINE_BITS;
   localparam int LINES   = 1 << LW;
   localparam int CKEY_W  = TAG_W + PID_W;

   // elaboration-time parameter checks
   if (ENTRY_BITS < 5) begin : g_chk_entries
      $error("pac_desc_array: ENTRY_BITS must give at least 32 slots");
   end
   if (LINE_BITS < 2 || LINE_BITS >= PAGE_BITS) begin : g_chk_line
      $error("pac_desc_array: need 2 <= LINE_BITS < PAGE_BITS");
   end
   if (PAGE_BITS >= ADDR_W) begin : g_chk_page
      $error("pac_desc_array: PAGE_BITS must be below ADDR_W");
   end
   if (PID_W < 1) begin : g_chk_pid
      $error("pac_desc_array: PID_W must be positive");
   end

   // slot state and tags
   ent_state_e         st_q    [ENTRIES];
   logic [TAG_W-1:0]   ptag_q  [ENTRIES];
   logic [TAG_W-1:0]   stag_q  [ENTRIES];
   logic [PID_W-1:0]   pid_q   [ENTRIES];
   logic [ENTRIES-1:0] pstat_q;

   logic [ENTRIES-1:0] live_v, snp_v, flush_hit;
   logic [ENTRIES-1:0] c_dirty, s_dirty;
   logic [ENTRIES-1:0][CKEY_W-1:0] cpu_keys;
   logic [ENTRIES-1:0][TAG_W-1:0]  snp_keys;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      assign live_v[i]    = (st_q[i] == ENT_LIVE);
      assign snp_v[i]     = (st_q[i] != ENT_FREE);
      assign flush_hit[i] = live_v[i] && (pid_q[i] == flush_pid);
      assign cpu_keys[i]  = {ptag_q[i], pid_q[i]};
      assign snp_keys[i]  = stag_q[i];
   end

   // gated update strobes
   logic alloc_ok, fill_ok, wr_ok;
   assign alloc_ok = alloc_en && !s_dirty[alloc_idx];
   assign fill_ok  = fill_en && live_v[fill_idx];
   assign wr_ok    = wr_en && live_v[wr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pstat_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            st_q[i]   <= ENT_FREE;
            ptag_q[i] <= '0;
            stag_q[i] <= '0;
            pid_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (alloc_ok && alloc_idx == ENTRY_BITS'(i)) begin
               st_q[i]    <= ENT_LIVE;
               ptag_q[i]  <= alloc_ptag;
               stag_q[i]  <= alloc_stag;
               pid_q[i]   <= alloc_pid;
               pstat_q[i] <= alloc_pstat;
            end else if (flush_en && flush_hit[i]) begin
               st_q[i] <= s_dirty[i] ? ENT_DRAIN : ENT_FREE;
            end else if (st_q[i] == ENT_DRAIN && !s_dirty[i]) begin
               st_q[i] <= ENT_FREE;
            end
         end
      end
   end

   // processor side lookup
   logic [ENTRIES-1:0] cpu_mv;
   line_attr_t         c_attr;
   logic [LINES-1:0]   c_sel_owned;
   logic [LW-1:0]      cpu_line;
   assign cpu_line = cpu_addr[PAGE_BITS-1:LINE_BITS];

   pac_match #(.N(ENTRIES), .KEY_W(CKEY_W)) u_cpu_match (
      .en(live_v), .keys(cpu_keys),
      .key({cpu_addr[ADDR_W-1:PAGE_BITS], cpu_pid}), .hit(cpu_mv)
   );
   pac_prio #(.N(ENTRIES)) u_cpu_prio (
      .req(cpu_mv), .found(cpu_page_hit), .idx(cpu_idx)
   );
   pac_line_store #(.N(ENTRIES), .LINES(LINES)) u_cpu_lines (
      .clk(clk), .rst_n(rst_n),
      .clr_en(alloc_ok), .clr_idx(alloc_idx),
      .fill_en(fill_ok), .fill_idx(fill_idx), .fill_line(fill_line), .fill_excl(fill_excl),
      .own_en(wr_ok), .own_idx(wr_idx), .own_line(wr_line),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_line(wb_line),
      .rd_idx(cpu_idx), .rd_line(cpu_line), .rd_attr(c_attr),
      .sel_idx(scan_idx), .sel_owned(c_sel_owned), .dirty(c_dirty)
   );
   assign cpu_attr  = cpu_page_hit ? c_attr : 3'b000;
   assign cpu_hit   = cpu_page_hit && c_attr.v;
   assign cpu_pstat = cpu_page_hit && pstat_q[cpu_idx];

   // bus side lookup
   logic [ENTRIES-1:0] snp_mv;
   line_attr_t         s_attr;
   logic [LINES-1:0]   s_sel_owned;
   logic [LW-1:0]      snp_line;
   assign snp_line = snp_addr[PAGE_BITS-1:LINE_BITS];

   pac_match #(.N(ENTRIES), .KEY_W(TAG_W)) u_snp_match (
      .en(snp_v), .keys(snp_keys),
      .key(snp_addr[ADDR_W-1:PAGE_BITS]), .hit(snp_mv)
   );
   pac_prio #(.N(ENTRIES)) u_snp_prio (
      .req(snp_mv), .found(snp_page_hit), .idx(snp_idx)
   );
   pac_line_store #(.N(ENTRIES), .LINES(LINES)) u_snp_lines (
      .clk(clk), .rst_n(rst_n),
      .clr_en(alloc_ok), .clr_idx(alloc_idx),
      .fill_en(fill_ok), .fill_idx(fill_idx), .fill_line(fill_line), .fill_excl(fill_excl),
      .own_en(wr_ok), .own_idx(wr_idx), .own_line(wr_line),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_line(wb_line),
      .rd_idx(snp_idx), .rd_line(snp_line), .rd_attr(s_attr),
      .sel_idx(scan_idx), .sel_owned(s_sel_owned), .dirty(s_dirty)
   );
   assign snp_attr  = snp_page_hit ? s_attr : 3'b000;
   assign ent_dirty = s_dirty;

   // replacement choice
   logic [ENTRIES-1:0] empty_v, clean_live_v;
   logic               empty_f, clean_f;
   logic [ENTRY_BITS-1:0] empty_i, clean_i;
   assign empty_v      = ~live_v & ~s_dirty;
   assign clean_live_v = live_v & ~s_dirty;

   pac_prio #(.N(ENTRIES)) u_empty_prio (.req(empty_v), .found(empty_f), .idx(empty_i));
   pac_prio #(.N(ENTRIES)) u_clean_prio (.req(clean_live_v), .found(clean_f), .idx(clean_i));
   assign victim_valid = empty_f || clean_f;
   assign victim_idx   = empty_f ? empty_i : clean_i;

   // next modified line search
   pac_prio #(.N(LINES)) u_scan_prio (.req(s_sel_owned), .found(scan_found), .idx(scan_line));

   // R10
   victim_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |-> !ent_dirty[victim_idx]);

   // R4
   alloc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_ok |=> !ent_dirty[$past(alloc_idx)]);

   // R3
   copy_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_page_hit && snp_page_hit && cpu_idx == snp_idx && cpu_line == snp_line)
      |-> cpu_attr == snp_attr);

   // R8
   copies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {c_dirty, c_sel_owned} == {s_dirty, s_sel_owned});

   for (genvar i = 0; i < ENTRIES; i++) begin : g_flush_chk
      // R9
      flush_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flush_en && flush_hit[i] && !(alloc_ok && alloc_idx == ENTRY_BITS'(i)))
         |=> st_q[i] != ENT_LIVE);
   end
endmodule

// File: tb/tb_pac_desc_array.sv
`timescale 1ns/1ps
module tb_pac_desc_array;
   localparam int AW = 32, PB = 10, LB = 6, EB = 5, PW = 8;
   localparam int TW = AW - PB;
   localparam int LW = PB - LB;
   localparam int NE = 1 << EB;
   localparam real CLK_NS = 8.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   logic [AW-1:LB] cpu_addr = '0, snp_addr = '0;
   logic [PW-1:0]  cpu_pid = '0, alloc_pid = '0, flush_pid = '0;
   logic cpu_page_hit, cpu_hit, cpu_pstat, snp_page_hit, victim_valid, scan_found;
   logic [EB-1:0] cpu_idx, snp_idx, victim_idx;
   logic [2:0] cpu_attr, snp_attr;
   logic alloc_en = 0, alloc_pstat = 0, fill_en = 0, fill_excl = 0, wr_en = 0, wb_en = 0, flush_en = 0;
   logic [EB-1:0] alloc_idx = '0, fill_idx = '0, wr_idx = '0, wb_idx = '0, scan_idx = '0;
   logic [TW-1:0] alloc_ptag = '0, alloc_stag = '0;
   logic [LW-1:0] fill_line = '0, wr_line = '0, wb_line = '0, scan_line;
   logic [NE-1:0] ent_dirty;

   pac_desc_array #(.ADDR_W(AW), .PAGE_BITS(PB), .LINE_BITS(LB), .ENTRY_BITS(EB), .PID_W(PW)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_addr(cpu_addr), .cpu_pid(cpu_pid), .cpu_page_hit(cpu_page_hit), .cpu_hit(cpu_hit),
      .cpu_idx(cpu_idx), .cpu_attr(cpu_attr), .cpu_pstat(cpu_pstat),
      .snp_addr(snp_addr), .snp_page_hit(snp_page_hit), .snp_idx(snp_idx), .snp_attr(snp_attr),
      .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_ptag(alloc_ptag), .alloc_stag(alloc_stag),
      .alloc_pid(alloc_pid), .alloc_pstat(alloc_pstat),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_line(fill_line), .fill_excl(fill_excl),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_line(wr_line),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_line(wb_line),
      .flush_en(flush_en), .flush_pid(flush_pid),
      .ent_dirty(ent_dirty), .victim_valid(victim_valid), .victim_idx(victim_idx),
      .scan_idx(scan_idx), .scan_found(scan_found), .scan_line(scan_line)
   );

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       req;
   } item_t;
   item_t q[$];

   int n_run = 0, n_fail = 0;
   bit done = 0;

   function automatic logic [AW-1:LB] mk(input int t, input int l);
      return {t[TW-1:0], l[LW-1:0]};
   endfunction

   function automatic logic [31:0] cexp(input bit ph, input bit h, input bit ps, input int i, input logic [2:0] a);
      return {21'b0, ph, h, ps, i[EB-1:0], a};
   endfunction

   function automatic logic [31:0] sexp(input bit ph, input int i, input logic [2:0] a);
      return {23'b0, ph, i[EB-1:0], a};
   endfunction

   function automatic logic [31:0] observe(input int kind);
      case (kind)
         0: return {21'b0, cpu_page_hit, cpu_hit, cpu_pstat, cpu_idx, cpu_attr};
         1: return {23'b0, snp_page_hit, snp_idx, snp_attr};
         2: return {26'b0, victim_valid, victim_idx};
         3: return {27'b0, scan_found, scan_line};
         default: return ent_dirty;
      endcase
   endfunction

   // monitor: compares queued expectations a little before the next rising edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = q.pop_front();
            got = observe(it.kind);
            n_run++;
            if (got !== it.exp) begin
               n_fail++;
               $display("FAIL %s kind %0d got %h expected %h", it.req, it.kind, got, it.exp);
            end
         end
      end
   end

   task automatic clr();
      alloc_en = 0; fill_en = 0; wr_en = 0; wb_en = 0; flush_en = 0;
   endtask

   task automatic idle();
      @(negedge clk); clr();
   endtask

   task automatic do_alloc(input int i, input int pt, input int st, input int p, input bit ps);
      @(negedge clk); clr();
      alloc_en = 1; alloc_idx = i[EB-1:0]; alloc_ptag = pt[TW-1:0]; alloc_stag = st[TW-1:0];
      alloc_pid = p[PW-1:0]; alloc_pstat = ps;
   endtask

   task automatic do_fill(input int i, input int l, input bit x);
      @(negedge clk); clr();
      fill_en = 1; fill_idx = i[EB-1:0]; fill_line = l[LW-1:0]; fill_excl = x;
   endtask

   task automatic do_write(input int i, input int l);
      @(negedge clk); clr();
      wr_en = 1; wr_idx = i[EB-1:0]; wr_line = l[LW-1:0];
   endtask

   task automatic do_wb(input int i, input int l);
      @(negedge clk); clr();
      wb_en = 1; wb_idx = i[EB-1:0]; wb_line = l[LW-1:0];
   endtask

   task automatic do_flush(input int p);
      @(negedge clk); clr();
      flush_en = 1; flush_pid = p[PW-1:0];
   endtask

   task automatic chk_cpu(input logic [AW-1:LB] a, input int p, input logic [31:0] e, input string r);
      @(negedge clk); clr();
      cpu_addr = a; cpu_pid = p[PW-1:0];
      q.push_back('{kind: 0, exp: e, req: r});
   endtask

   task automatic chk_snp(input logic [AW-1:LB] a, input logic [31:0] e, input string r);
      @(negedge clk); clr();
      snp_addr = a;
      q.push_back('{kind: 1, exp: e, req: r});
   endtask

   task automatic chk_scan(input int i, input logic [31:0] e, input string r);
      @(negedge clk); clr();
      scan_idx = i[EB-1:0];
      q.push_back('{kind: 3, exp: e, req: r});
   endtask

   task automatic chk_plain(input int kind, input logic [31:0] e, input string r);
      @(negedge clk); clr();
      q.push_back('{kind: kind, exp: e, req: r});
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_cpu(mk(5, 0), 1, 32'h0, "R1 cpu lookup after reset");
      chk_snp(mk(5, 0), 32'h0, "R1 snoop lookup after reset");
      chk_plain(2, {26'b0, 1'b1, 5'd0}, "R1 victim after reset");
      chk_plain(4, 32'h0, "R1 dirty after reset");

      // R2 R4 allocation and lookups
      do_alloc(0, 'h100, 'h2A0, 3, 1'b1);
      chk_cpu(mk('h100, 2), 3, cexp(1, 0, 1, 0, 3'b000), "R2 R4 page hit after alloc");
      chk_cpu(mk('h100, 2), 4, 32'h0, "R2 other pid misses");
      chk_snp(mk('h2A0, 2), sexp(1, 0, 3'b000), "R3 snoop physical tag");
      chk_snp(mk('h100, 2), 32'h0, "R3 snoop ignores processor tag");
      chk_plain(2, {26'b0, 1'b1, 5'd1}, "R10 victim skips live slot");

      // R5 fill
      do_fill(0, 2, 1'b1);
      chk_cpu(mk('h100, 2), 3, cexp(1, 1, 1, 0, 3'b110), "R5 fill exclusive cpu copy");
      chk_snp(mk('h2A0, 2), sexp(1, 0, 3'b110), "R5 fill exclusive bus copy");

      // R6 write to invalid line ignored, then to valid line
      do_write(0, 5);
      chk_cpu(mk('h100, 5), 3, cexp(1, 0, 1, 0, 3'b000), "R6 write invalid line ignored");
      chk_plain(4, 32'h0, "R6 R8 no dirty after ignored write");
      do_write(0, 2);
      chk_cpu(mk('h100, 2), 3, cexp(1, 1, 1, 0, 3'b111), "R6 owned set cpu copy");
      chk_snp(mk('h2A0, 2), sexp(1, 0, 3'b111), "R6 owned set bus copy");
      chk_plain(4, 32'h1, "R8 dirty slot 0");

      // R11 R7 scan and write-back
      do_alloc(1, 'h200, 'h3B0, 3, 1'b0);
      do_fill(1, 7, 1'b0);
      do_fill(1, 3, 1'b0);
      do_write(1, 7);
      do_write(1, 3);
      chk_scan(1, {27'b0, 1'b1, 4'd3}, "R11 lowest owned line");
      do_wb(1, 3);
      chk_scan(1, {27'b0, 1'b1, 4'd7}, "R11 R7 next owned after wb");
      chk_cpu(mk('h200, 3), 3, cexp(1, 1, 0, 1, 3'b100), "R7 wb clears owned");
      chk_plain(4, 32'h3, "R8 two dirty slots");

      do_alloc(2, 'h300, 'h3C0, 9, 1'b0);
      chk_plain(2, {26'b0, 1'b1, 5'd3}, "R10 lowest empty slot");

      // R4 allocation into dirty slot ignored
      do_alloc(0, 'h555, 'h666, 7, 1'b0);
      chk_cpu(mk('h100, 2), 3, cexp(1, 1, 1, 0, 3'b111), "R4 dirty slot kept");
      chk_cpu(mk('h555, 0), 7, 32'h0, "R4 rejected tag absent");

      // R9 flush by process
      do_flush(3);
      chk_cpu(mk('h100, 2), 3, 32'h0, "R9 flushed slot 0 gone from cpu");
      chk_cpu(mk('h200, 7), 3, 32'h0, "R9 flushed slot 1 gone from cpu");
      chk_snp(mk('h2A0, 2), sexp(1, 0, 3'b111), "R9 draining slot still snooped");
      chk_snp(mk('h3B0, 7), sexp(1, 1, 3'b101), "R9 R3 draining slot 1 snooped");
      chk_cpu(mk('h300, 0), 9, cexp(1, 0, 0, 2, 3'b000), "R9 other pid untouched");
      chk_plain(2, {26'b0, 1'b1, 5'd3}, "R9 R10 draining not replaceable");
      do_fill(0, 4, 1'b1);
      chk_snp(mk('h2A0, 4), sexp(1, 0, 3'b000), "R5 fill to draining slot ignored");

      do_wb(0, 2);
      idle();
      chk_snp(mk('h2A0, 2), 32'h0, "R9 drained slot freed");
      chk_plain(2, {26'b0, 1'b1, 5'd0}, "R10 freed slot chosen");
      chk_plain(4, 32'h2, "R8 only slot 1 dirty");

      // R10 all slots dirty
      for (int i = 0; i < NE; i++) begin
         do_alloc(i, 'h1000 + i, 'h2000 + i, 20, 1'b0);
         do_fill(i, 0, 1'b1);
         do_write(i, 0);
      end
      chk_plain(2, 32'h0, "R10 no victim when all dirty");
      chk_plain(4, 32'hFFFF_FFFF, "R8 all dirty");
      chk_cpu(mk('h1001, 0), 20, 32'h0, "R4 draining dirty slot not reloaded");
      chk_cpu(mk('h1005, 0), 20, cexp(1, 1, 0, 5, 3'b111), "R2 reloaded slot hit");
      do_wb(17, 0);
      chk_plain(2, {26'b0, 1'b1, 5'd17}, "R10 lowest live clean slot");
      chk_scan(5, {27'b0, 1'b1, 4'd0}, "R11 owned line 0");
      chk_scan(17, 32'h0, "R11 clean slot not found");

      idle();
      idle();
      done = 1;
      finish_run();
   end
endmodule